// File: doc/BRIEF.md
# Sequence Period Checker

This block watches the state vector of a free-running N-bit code generator and classifies the sequence the generator produces. A one-cycle start pulse arms it. From then on it counts clocks and compares the incoming state against a seed value and against all zeros. When the run ends, it raises a done flag and reports the outcome and the step count:

- a maximal-length sequence,
- a short cycle,
- a collapse to all zeros, or
- a run that never came back.

The generator is expected to load its seed on the same clock edge that samples the start pulse. The state seen in the following cycle is therefore step 0, and each later cycle adds one step. The checker keeps no memory of visited states. It recognises only a return to the seed and the all-zero state. This keeps its cost at one counter and two comparators, whatever the register width.

Top module: `seqchk_period`

## Requirements
- R1: After reset, done is 0, status is 2'b00 and steps is 0.
- R2: While checking, an all-zero state ends the run with done=1, status 2'b10 (zero-lock), and steps equal to the number of advances that came before the zero state.
- R3: A return to the seed after exactly 2^N-1 advances ends the run with status 2'b00 (maximal) and steps = 2^N-1.
- R4: A return to the seed after fewer than 2^N-1 advances ends the run with status 2'b01 (short period) and steps equal to the period.
- R5: If 2^N advances pass without a return to the seed or a zero state, the run ends with status 2'b11 (timeout) and steps = 2^N. The steps output never exceeds 2^N.
- R6: Once done is 1, done, status and steps stay unchanged until the next start pulse, whatever the state input does.
- R7: A start pulse clears done and sets steps to 0 on the clock edge that samples it. In the cycle after start, the state is step 0, and a match with the seed at step 0 is not counted as a return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that begins a check |
| state_i | input | WIDTH | Current state of the generator under test |
| seed_i | input | WIDTH | Value the generator was started from |
| done_o | output | 1 | High once a verdict is available |
| status_o | output | 2 | 00 maximal, 01 short period, 10 zero-lock, 11 timeout |
| steps_o | output | WIDTH+1 | Advances counted in the current or last run |

## Verification
The bench builds two copies of the checker: one with WIDTH=3 and one with WIDTH=9. Each copy is paired with a shift-left generator whose feedback mask toggles the taps. With WIDTH=3, every verdict can be reached in a few cycles:

- a maximal 7-step run,
- a 3-step short cycle,
- zero-lock at step 0 (generator seeded with zero),
- zero-lock at step 3 (generator with an empty mask),
- timeout at step 8 (seed input that is never visited).

With WIDTH=9, a 511-step maximal run and a 9-step short cycle exercise the full counter width and the 2^N-1 comparison at a realistic size.

// File: rtl/seqchk_pkg.sv
package seqchk_pkg;

    typedef enum logic [1:0] {
        VERDICT_MAXIMAL = 2'b00,
        VERDICT_SHORT   = 2'b01,
        VERDICT_ZERO    = 2'b10,
        VERDICT_TIMEOUT = 2'b11
    } verdict_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef struct packed {
        logic at_zero;
        logic at_seed;
    } match_t;

    function automatic verdict_e verdict_on_return(input logic full_period);
        return full_period ? VERDICT_MAXIMAL : VERDICT_SHORT;
    endfunction

endpackage

// File: rtl/seqchk_counter.sv
module seqchk_counter #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (inc)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/seqchk_match.sv
module seqchk_match
    import seqchk_pkg::*;
#(
    parameter int WIDTH = 9
) (
    input  logic [WIDTH-1:0] state,
    input  logic [WIDTH-1:0] seed,
    input  logic             past_step0,
    output match_t           hit
);
    always_comb begin
        hit.at_zero = (state == '0);
        hit.at_seed = past_step0 && (state == seed);
    end
endmodule

// File: rtl/seqchk_period.sv
module seqchk_period
    import seqchk_pkg::*;
#(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [WIDTH-1:0] state_i,
    input  logic [WIDTH-1:0] seed_i,
    output logic             done_o,
    output logic [1:0]       status_o,
    output logic [WIDTH:0]   steps_o
);
    localparam int CW = WIDTH + 1;
    localparam logic [CW-1:0] FULL_PERIOD = {1'b0, {WIDTH{1'b1}}};
    localparam logic [CW-1:0] STEP_LIMIT  = {1'b1, {WIDTH{1'b0}}};

    phase_e        phase;
    verdict_e      verdict;
    logic          done_q;
    logic [CW-1:0] steps;
    match_t        hit;
    logic          finish;
    verdict_e      verdict_next;

    seqchk_match #(.WIDTH(WIDTH)) u_match (
        .state      (state_i),
        .seed       (seed_i),
        .past_step0 (steps != '0),
        .hit        (hit)
    );

    always_comb begin
        finish       = 1'b0;
        verdict_next = verdict;
        if (phase == PH_RUN) begin
            if (hit.at_zero) begin
                finish       = 1'b1;
                verdict_next = VERDICT_ZERO;
            end else if (hit.at_seed) begin
                finish       = 1'b1;
                verdict_next = verdict_on_return(steps == FULL_PERIOD);
            end else if (steps == STEP_LIMIT) begin
                finish       = 1'b1;
                verdict_next = VERDICT_TIMEOUT;
            end
        end
    end

    seqchk_counter #(.CW(CW)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .clr   (start_i),
        .inc   ((phase == PH_RUN) && !finish),
        .count (steps)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            done_q  <= 1'b0;
            verdict <= VERDICT_MAXIMAL;
        end else if (start_i) begin
            phase   <= PH_RUN;
            done_q  <= 1'b0;
            verdict <= VERDICT_MAXIMAL;
        end else if (finish) begin
            phase   <= PH_IDLE;
            done_q  <= 1'b1;
            verdict <= verdict_next;
        end
    end

    assign done_o   = done_q;
    assign status_o = verdict;
    assign steps_o  = steps;

    // R6
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        (done_q && !start_i) |=> (done_q && $stable(status_o) && $stable(steps_o)));

    // R7
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!done_o && steps_o == '0));

    // R5
    step_bound_chk: assert property (@(posedge clk) disable iff (rst)
        steps_o <= STEP_LIMIT);

    // R3
    maximal_count_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && status_o == VERDICT_MAXIMAL) |-> steps_o == FULL_PERIOD);

    // R2
    zero_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN && !start_i && state_i == '0) |=> (done_o && status_o == VERDICT_ZERO));

endmodule

// File: tb/seqchk_period_tb.sv
module seqchk_period_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [1:0] st;
        int         steps;
        string      tag;
    } exp_t;
    exp_t sb[$];

    logic       st3 = 1'b0, st9 = 1'b0;
    logic [2:0] m3 = '0, gs3 = '0, cs3 = '0, g3;
    logic [8:0] m9 = '0, gs9 = '0, cs9 = '0, g9;
    logic       dn3, dn9;
    logic [1:0] s3, s9;
    logic [3:0] k3;
    logic [9:0] k9;

    always_ff @(posedge clk) begin
        if (st3) g3 <= gs3;
        else     g3 <= {g3[1:0], 1'b0} ^ (g3[2] ? m3 : 3'b0);
        if (st9) g9 <= gs9;
        else     g9 <= {g9[7:0], 1'b0} ^ (g9[8] ? m9 : 9'b0);
    end

    seqchk_period #(.WIDTH(3)) u_dut (
        .clk(clk), .rst(rst), .start_i(st3), .state_i(g3), .seed_i(cs3),
        .done_o(dn3), .status_o(s3), .steps_o(k3));

    seqchk_period #(.WIDTH(9)) u_dut_w9 (
        .clk(clk), .rst(rst), .start_i(st9), .state_i(g9), .seed_i(cs9),
        .done_o(dn9), .status_o(s9), .steps_o(k9));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pop_cmp(input logic [1:0] st, input int steps);
        exp_t e;
        if (sb.size() == 0) begin
            check(1'b0, "scoreboard-empty", int'(st), -1);
        end else begin
            e = sb.pop_front();
            check(st == e.st, {e.tag, " status"}, int'(st), int'(e.st));
            check(steps == e.steps, {e.tag, " steps"}, steps, e.steps);
        end
    endtask

    logic p3 = 1'b0, p9 = 1'b0;
    always @(negedge clk) begin
        if (!rst && dn3 && !p3) pop_cmp(s3, int'(k3));
        if (!rst && dn9 && !p9) pop_cmp(s9, int'(k9));
        p3 = dn3;
        p9 = dn9;
    end

    task automatic run_case(input bit wide, input logic [8:0] mask, input logic [8:0] gseed,
                            input logic [8:0] cseed, input logic [1:0] est, input int esteps,
                            input string tag);
        exp_t e;
        logic [1:0] hs;
        int hk;
        @(negedge clk);
        e.st = est; e.steps = esteps; e.tag = tag;
        sb.push_back(e);
        if (wide) begin m9 = mask; gs9 = gseed; cs9 = cseed; st9 = 1'b1; end
        else begin m3 = mask[2:0]; gs3 = gseed[2:0]; cs3 = cseed[2:0]; st3 = 1'b1; end
        @(negedge clk);
        st3 = 1'b0; st9 = 1'b0;
        // R7: start cleared done and steps
        check(!(wide ? dn9 : dn3), "R7 done cleared", int'(wide ? dn9 : dn3), 0);
        check((wide ? int'(k9) : int'(k3)) == 0, "R7 steps cleared", wide ? int'(k9) : int'(k3), 0);
        for (int i = 0; i < 2000; i++) begin
            if (wide ? dn9 : dn3) break;
            @(negedge clk);
        end
        hs = wide ? s9 : s3;
        hk = wide ? int'(k9) : int'(k3);
        repeat (5) @(negedge clk);
        // R6: frozen result while the generator keeps running
        check((wide ? dn9 : dn3) == 1'b1, "R6 done held", int'(wide ? dn9 : dn3), 1);
        check((wide ? s9 : s3) == hs, "R6 status held", int'(wide ? s9 : s3), int'(hs));
        check((wide ? int'(k9) : int'(k3)) == hk, "R6 steps held", wide ? int'(k9) : int'(k3), hk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(dn3 == 1'b0 && dn9 == 1'b0, "R1 done", int'(dn3), 0);
        check(s3 == 2'b00 && s9 == 2'b00, "R1 status", int'(s3), 0);
        check(k3 == '0 && k9 == '0, "R1 steps", int'(k3), 0);

        run_case(1'b0, 9'h003, 9'h001, 9'h001, 2'b00, 7,   "R3 w3 maximal");
        run_case(1'b0, 9'h001, 9'h001, 9'h001, 2'b01, 3,   "R4 w3 short");
        run_case(1'b0, 9'h003, 9'h000, 9'h001, 2'b10, 0,   "R2 w3 zero seed");
        run_case(1'b0, 9'h000, 9'h001, 9'h001, 2'b10, 3,   "R2 w3 decay");
        run_case(1'b0, 9'h003, 9'h001, 9'h000, 2'b11, 8,   "R5 w3 timeout");
        run_case(1'b1, 9'h021, 9'h001, 9'h001, 2'b00, 511, "R3 w9 maximal");
        run_case(1'b1, 9'h001, 9'h001, 9'h001, 2'b01, 9,   "R4 w9 short");
        run_case(1'b1, 9'h021, 9'h000, 9'h001, 2'b10, 0,   "R2 w9 zero seed");

        check(sb.size() == 0, "scoreboard drained", sb.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule